// File: doc/BRIEF.md
# Chained buffer descriptor DMA engine

This block moves frames between a byte stream and memory by following a linked list of buffer descriptors that host software has already placed in memory. Software writes the address of the first descriptor and pulses a start input. The engine then reads each descriptor in turn. Every descriptor carries its own direction, so one chain can mix receive and transmit work.

For a receive descriptor, the engine packs incoming stream bytes into its buffer. For a transmit descriptor, it reads the buffer and sends the bytes out. After each descriptor it writes back a byte count and a completion flag, and then follows the next pointer. Software handles no individual bus word. It only polls the completion flags or waits for the end-of-chain pulse.

A descriptor that still carries a completion flag from an earlier pass has not yet been reclaimed by software. The engine stops at it, reports an ownership error, and re-reads it until software clears the flag.

Top module: `chain_dma`

## Requirements
- R1: When `start` is high while the engine is idle, `busy` is high from the next cycle and the first descriptor read is at `head_ptr`. A `start` pulse while `busy` is high is ignored.
- R2: A descriptor is four 32-bit words at a pointer P. P+0 holds the next pointer. P+4 holds the word-aligned buffer byte address. P+8 is the control word: bit 31 is the command (1 = transmit, 0 = receive), bit 30 is done, bit 29 is overflow, and bits 15:0 are the buffer length in bytes. P+12 receives the byte count. Descriptors are handled strictly in list order.
- R3: Receive bytes are stored little-endian: byte n of the frame goes to bits 8*(n%4)+7 : 8*(n%4) of the word at buffer+4*(n/4). The last, partly filled word is written with zeros in its unused upper bytes, and no later word is touched. `rx_ready` is high only while a receive descriptor is being served.
- R4: Receive bytes beyond the buffer length are accepted and discarded, with no memory write. The descriptor then gets overflow bit 29 set, and P+12 gets the buffer length.
- R5: A transmit descriptor sends exactly `length` bytes in buffer order, with byte lane 0 of each word first. `tx_last` is high only on the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R6: On finishing a descriptor, the engine writes the stored or sent byte count to P+12. It then writes P+8 with done set, overflow set to the descriptor's outcome, and all other bits unchanged.
- R7: After a descriptor whose next pointer is zero, `busy` falls and `chain_done` is high for exactly one cycle, in the same cycle that `busy` is first low.
- R8: If a fetched control word already has done set, the engine writes nothing, drives no stream handshake, and holds `own_err` high. It keeps re-reading that descriptor. Once software clears done, it serves the descriptor normally and `own_err` falls.
- R9: A transmit descriptor of length zero sends no byte and completes with a count of 0.
- R10: During reset, `busy`, `chain_done`, `own_err`, `mem_en`, `rx_ready` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin walking the chain at head_ptr |
| head_ptr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | Engine is walking a chain |
| chain_done | output | 1 | One-cycle pulse at the end of the chain |
| own_err | output | 1 | Stalled on a descriptor that is still marked done |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte ends the frame |
| rx_ready | output | 1 | Engine accepts a receive byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends the frame |
| tx_ready | input | 1 | Sink accepts the transmit byte |

## Verification
The bench drives frames that are shorter than, equal to and longer than their buffers, including a zero-length buffer and lengths that end mid-word.

- An engine that keeps writing after the buffer is full overwrites the sentinel word beyond it.
- One that mishandles the final partial word leaves stale bytes in it or drops it.
- One that ignores `tx_ready` stalls sends the wrong number of bytes or repeats bytes.

A mixed receive, transmit and zero-length chain exposes out-of-order walking, as well as writebacks that lose the command bit. A descriptor that is pre-marked done must park the engine with no writes. A design that trusts the flag corrupts a buffer that software still owns.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;
  localparam int CMD_TX_BIT = 31;
  localparam int DONE_BIT   = 30;
  localparam int OVF_BIT    = 29;

  localparam logic [1:0] IDX_NEXT = 2'd0;
  localparam logic [1:0] IDX_BUF  = 2'd1;
  localparam logic [1:0] IDX_CTL  = 2'd2;
  localparam logic [1:0] IDX_CNT  = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECIDE, S_RX, S_RX_WR, S_TX_RD, S_TX_WAIT,
    S_TX_OUT, S_WB_CNT, S_WB_CTL, S_NEXT
  } cdma_state_t;

  // Byte address of the descriptor word at index idx.
  function automatic logic [WORD_W-1:0] desc_addr(input logic [WORD_W-1:0] base,
                                                  input logic [1:0] idx);
    return base + {{(WORD_W-4){1'b0}}, idx, 2'b00};
  endfunction

  // Byte address of the buffer word holding byte number nbytes.
  function automatic logic [WORD_W-1:0] buf_addr(input logic [WORD_W-1:0] base,
                                                 input logic [LEN_W-1:0] nbytes);
    return base + {{(WORD_W-LEN_W){1'b0}}, nbytes[LEN_W-1:2], 2'b00};
  endfunction

  // Control word written back on completion: done set, overflow replaced.
  function automatic logic [WORD_W-1:0] ctl_done(input logic [WORD_W-1:0] ctl,
                                                 input logic ovf);
    logic [WORD_W-1:0] w;
    w = ctl;
    w[DONE_BIT] = 1'b1;
    w[OVF_BIT]  = ovf;
    return w;
  endfunction
endpackage

// File: rtl/cdma_rx_pack.sv
module cdma_rx_pack #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clr,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (clr)                             q <= '0;
      else if (take && lane == LANE_W'(g))      q <= din;
    end
    assign word[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/cdma_tx_unpack.sv
module cdma_tx_unpack #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [LANE_W-1:0] lane,
  output logic [BYTE_W-1:0] byte_out
);
  logic [WORD_W-1:0] word_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end
  assign byte_out = word_q[int'(lane)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import cdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] head_ptr,
  output logic        busy,
  output logic        chain_done,
  output logic        own_err,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int LANE_W = $clog2(WORD_W / BYTE_W);

  cdma_state_t       state;
  logic [WORD_W-1:0] cur_ptr, nxt_ptr, buf_ptr, ctl_q, wr_addr;
  logic [1:0]        fcnt;
  logic [LEN_W-1:0]  cnt;
  logic              ovf, last_seen, done_q, err_q;

  logic              is_tx;
  logic [LEN_W-1:0]  blen;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] pack_word;

  // Named internal events, also used by the checker.
  logic rx_take, rx_store, rx_drop, rx_flush, tx_fire, stall_evt, wb_ctl_wr;

  assign is_tx     = ctl_q[CMD_TX_BIT];
  assign blen      = ctl_q[LEN_W-1:0];
  assign lane      = cnt[LANE_W-1:0];
  assign rx_ready  = (state == S_RX);
  assign rx_take   = rx_ready && rx_valid;
  assign rx_store  = rx_take && (cnt < blen);
  assign rx_drop   = rx_take && !(cnt < blen);
  assign rx_flush  = rx_store && ((&lane) || rx_last || (cnt + 16'd1 == blen));
  assign tx_valid  = (state == S_TX_OUT);
  assign tx_last   = tx_valid && (cnt + 16'd1 == blen);
  assign tx_fire   = tx_valid && tx_ready;
  assign stall_evt = (state == S_DECIDE) && ctl_q[DONE_BIT];
  assign wb_ctl_wr = (state == S_WB_CTL);
  assign busy       = (state != S_IDLE);
  assign chain_done = done_q;
  assign own_err    = err_q;

  cdma_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(rx_store), .clr(state == S_RX_WR),
    .lane(lane), .din(rx_data), .word(pack_word)
  );

  cdma_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(state == S_TX_WAIT), .word_in(mem_rdata),
    .lane(lane), .byte_out(tx_data)
  );

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_en   = (fcnt != IDX_CNT);
        mem_addr = desc_addr(cur_ptr, fcnt);
      end
      S_RX_WR: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = wr_addr; mem_wdata = pack_word;
      end
      S_TX_RD: begin
        mem_en = 1'b1;
        mem_addr = buf_addr(buf_ptr, cnt);
      end
      S_WB_CNT: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = desc_addr(cur_ptr, IDX_CNT);
        mem_wdata = {{(WORD_W-LEN_W){1'b0}}, cnt};
      end
      S_WB_CTL: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = desc_addr(cur_ptr, IDX_CTL);
        mem_wdata = ctl_done(ctl_q, ovf);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur_ptr <= '0; nxt_ptr <= '0; buf_ptr <= '0; ctl_q <= '0; wr_addr <= '0;
      fcnt <= '0; cnt <= '0; ovf <= 1'b0; last_seen <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur_ptr <= head_ptr;
          fcnt    <= '0;
          state   <= S_FETCH;
        end
        S_FETCH: begin
          fcnt <= fcnt + 2'd1;
          case (fcnt)
            IDX_BUF:  nxt_ptr <= mem_rdata;
            IDX_CTL:  buf_ptr <= mem_rdata;
            IDX_CNT: begin
              ctl_q <= mem_rdata;
              state <= S_DECIDE;
            end
            default: ;
          endcase
        end
        S_DECIDE: begin
          cnt <= '0; ovf <= 1'b0; last_seen <= 1'b0;
          if (stall_evt) begin
            err_q <= 1'b1;
            fcnt  <= '0;
            state <= S_FETCH;
          end else begin
            err_q <= 1'b0;
            if (!is_tx)          state <= S_RX;
            else if (blen == '0) state <= S_WB_CNT;
            else                 state <= S_TX_RD;
          end
        end
        S_RX: begin
          if (rx_store) begin
            cnt     <= cnt + 16'd1;
            wr_addr <= buf_addr(buf_ptr, cnt);
            if (rx_flush) begin
              last_seen <= rx_last;
              state     <= S_RX_WR;
            end
          end
          if (rx_drop) begin
            ovf <= 1'b1;
            if (rx_last) state <= S_WB_CNT;
          end
        end
        S_RX_WR:   state <= last_seen ? S_WB_CNT : S_RX;
        S_TX_RD:   state <= S_TX_WAIT;
        S_TX_WAIT: state <= S_TX_OUT;
        S_TX_OUT: if (tx_fire) begin
          cnt <= cnt + 16'd1;
          if (tx_last)     state <= S_WB_CNT;
          else if (&lane)  state <= S_TX_RD;
        end
        S_WB_CNT: state <= S_WB_CTL;
        S_WB_CTL: state <= S_NEXT;
        S_NEXT: begin
          if (nxt_ptr == '0) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            cur_ptr <= nxt_ptr;
            fcnt    <= '0;
            state   <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdma_checks.sv
module cdma_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       chain_done,
  input logic       own_err,
  input logic       mem_en,
  input logic       mem_we,
  input logic [31:0] mem_wdata,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       wb_ctl_wr
);
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r3_rx_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> busy && !tx_valid);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r6_done_written: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ctl_wr |-> mem_en && mem_we && mem_wdata[30]);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done);

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy);

  a_r8_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    own_err |-> !(mem_en && mem_we));

  a_r8_stall_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    own_err |-> busy && !rx_ready && !tx_valid);
endmodule

bind chain_dma cdma_checks u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .chain_done(chain_done),
  .own_err(own_err), .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .wb_ctl_wr(wb_ctl_wr)
);

// File: tb/tb_chain_dma.sv
module tb_chain_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  // Receive vectors: {buffer length, frame length}
  localparam logic [31:0] RX_VEC [7] = '{
    {16'd8, 16'd8}, {16'd8, 16'd5}, {16'd3, 16'd7}, {16'd6, 16'd6},
    {16'd1, 16'd1}, {16'd0, 16'd3}, {16'd5, 16'd12}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] head_ptr = 0;
  logic busy, chain_done, own_err, mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic rx_valid = 0, rx_last = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_last, tx_ready = 1;
  logic [7:0] tx_data;

  logic [31:0] mem [0:255];
  logic hw_en = 0;
  logic [31:0] hw_addr = 0, hw_data = 0;

  int checks = 0, errors = 0;
  int cap_n;
  logic [7:0] cap_d [16];
  logic cap_l [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_dma dut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr), .busy(busy),
    .chain_done(chain_done), .own_err(own_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
    end
    if (hw_en) mem[hw_addr[9:2]] <= hw_data;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((seed * 16 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] rx_word(input int seed, input int k, input int stored);
    logic [31:0] w = 0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < stored) w[8*j +: 8] = byte_of(seed, 4 * k + j);
    return w;
  endfunction

  task automatic mw(input logic [31:0] a, input logic [31:0] d);
    hw_en = 1; hw_addr = a; hw_data = d;
    @(posedge clk); #1 hw_en = 0;
  endtask

  task automatic set_desc(input logic [31:0] p, input logic [31:0] nxt,
                          input logic [31:0] b, input logic [31:0] ctl);
    mw(p, nxt); mw(p + 4, b); mw(p + 8, ctl); mw(p + 12, 32'hFFFF_FFFF);
  endtask

  task automatic pulse_start(input logic [31:0] h);
    start = 1; head_ptr = h;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic send_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = byte_of(seed, i); rx_last = (i == n - 1);
      forever begin
        @(negedge clk);
        if (rx_ready) begin @(posedge clk); #1; break; end
        @(posedge clk); #1;
      end
    end
    rx_valid = 0; rx_last = 0;
  endtask

  // Watches the transmit side and the end of the chain; pat=1 throttles tx_ready.
  task automatic run_until_done(input int pat, output bit ok);
    ok = 0; cap_n = 0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (tx_valid && tx_ready && cap_n < 16) begin
        cap_d[cap_n] = tx_data; cap_l[cap_n] = tx_last; cap_n++;
      end
      if (chain_done) begin
        ok = 1;
        chk(!busy, "R7", "busy low with chain_done", 32'(busy), 0);
        @(negedge clk);
        chk(!chain_done, "R7", "chain_done one cycle", 32'(chain_done), 0);
        break;
      end
      @(posedge clk); #1 tx_ready = (pat == 0) ? 1'b1 : ((t % 3) != 0);
    end
    tx_ready = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual hung expected chain end");
    finish_up();
  end

  initial begin
    bit ok;
    repeat (2) @(posedge clk); #1;
    // R10: reset state
    chk({busy, chain_done, own_err, mem_en, rx_ready, tx_valid} == 6'b0, "R10",
        "outputs in reset", 32'({busy, chain_done, own_err, mem_en, rx_ready, tx_valid}), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // Table-driven receive cases (R3, R4, R6)
    for (int v = 0; v < 7; v++) begin
      int blen, flen, stored, nw;
      bit ov, good;
      logic [31:0] bad;
      blen = int'(RX_VEC[v][31:16]); flen = int'(RX_VEC[v][15:0]);
      stored = (flen < blen) ? flen : blen;
      ov = (flen > blen);
      nw = (stored + 3) / 4;
      set_desc(32'h0, 32'h0, 32'h100, 32'(blen));
      for (int k = 0; k < 8; k++) mw(32'h100 + 32'(4 * k), SENT);
      pulse_start(32'h0);
      fork
        send_frame(flen, v + 1);
        run_until_done(0, ok);
      join
      chk(ok, "R7", "receive chain ended", 32'(ok), 1);
      chk(mem[2] == {1'b0, 1'b1, ov, 13'b0, 16'(blen)}, ov ? "R4" : "R6",
          "rx control writeback", mem[2], {1'b0, 1'b1, ov, 13'b0, 16'(blen)});
      chk(mem[3] == 32'(stored), ov ? "R4" : "R6", "rx stored count", mem[3], 32'(stored));
      good = 1; bad = 0;
      for (int k = 0; k <= nw && k < 8; k++) begin
        logic [31:0] e;
        e = (k < nw) ? rx_word(v + 1, k, stored) : SENT;
        if (mem[64 + k] != e) begin good = 0; bad = mem[64 + k]; end
      end
      chk(good, ov ? "R4" : "R3", "rx buffer contents and sentinel", bad, 0);
    end

    // Mixed chain: rx (4) -> tx (6) -> tx (0). R2, R5, R6, R9
    set_desc(32'h40, 32'h80, 32'h180, 32'd4);
    set_desc(32'h80, 32'hC0, 32'h200, 32'h8000_0006);
    set_desc(32'hC0, 32'h0,  32'h200, 32'h8000_0000);
    mw(32'h200, 32'h4433_2211); mw(32'h204, 32'h8877_6655);
    mw(32'h180, SENT); mw(32'h184, SENT);
    pulse_start(32'h40);
    fork
      send_frame(4, 9);
      run_until_done(1, ok);
    join
    chk(ok, "R7", "mixed chain ended", 32'(ok), 1);
    chk(mem[18] == 32'h4000_0004, "R2", "rx desc done", mem[18], 32'h4000_0004);
    chk(mem[96] == rx_word(9, 0, 4) && mem[97] == SENT, "R3", "rx buffer in chain",
        mem[96], rx_word(9, 0, 4));
    chk(mem[34] == 32'hC000_0006, "R6", "tx desc done, command kept", mem[34], 32'hC000_0006);
    chk(mem[35] == 32'd6, "R6", "tx count", mem[35], 6);
    chk(cap_n == 6, "R5", "tx byte count under backpressure", 32'(cap_n), 6);
    for (int k = 0; k < 6 && k < cap_n; k++) begin
      logic [7:0] e;
      e = 8'(mem[128 + k / 4] >> (8 * (k % 4)));
      chk(cap_d[k] == e && cap_l[k] == (k == 5), "R5", $sformatf("tx byte %0d", k),
          {23'b0, cap_l[k], cap_d[k]}, {23'b0, k == 5, e});
    end
    chk(mem[50] == 32'hC000_0000 && mem[51] == 0, "R9", "zero-length tx completes",
        mem[51], 0);

    // Ownership stall (R8)
    set_desc(32'h0, 32'h0, 32'h100, 32'h4000_0004);
    mw(32'h100, SENT);
    pulse_start(32'h0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(own_err && busy && !rx_ready, "R8", "stalled with error flag",
        32'({own_err, busy, rx_ready}), 32'b110);
    chk(mem[2] == 32'h4000_0004 && mem[3] == 32'hFFFF_FFFF && mem[64] == SENT, "R8",
        "nothing written while stalled", mem[3], 32'hFFFF_FFFF);
    @(posedge clk); #1;
    mw(32'h8, 32'h0000_0004);
    fork
      send_frame(4, 12);
      run_until_done(0, ok);
    join
    chk(ok && !own_err, "R8", "resumes after release", 32'(own_err), 0);
    chk(mem[2] == 32'h4000_0004 && mem[64] == rx_word(12, 0, 4), "R8",
        "released descriptor served", mem[64], rx_word(12, 0, 4));

    // Start while busy is ignored (R1)
    set_desc(32'h0, 32'h0, 32'h100, 32'd4);
    set_desc(32'h40, 32'h0, 32'h200, 32'h8000_0002);
    pulse_start(32'h0);
    chk(busy, "R1", "busy after start", 32'(busy), 1);
    repeat (3) @(posedge clk); #1;
    pulse_start(32'h40);
    fork
      send_frame(4, 13);
      run_until_done(0, ok);
    join
    chk(mem[18] == 32'h8000_0002 && cap_n == 0, "R1", "second start ignored",
        mem[18], 32'h8000_0002);
    chk(mem[2] == 32'h4000_0004, "R1", "head descriptor served", mem[2], 32'h4000_0004);

    finish_up();
  end
endmodule